// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block steers operands and holds the front end of a five-stage in-order integer pipeline. For the instruction sitting in decode, it compares each source register index against the destination of the two older instructions still in flight: the one in execute and the one in the memory stage. From those comparisons it picks where each execute-stage operand comes from. The choices are the register file, the execute/memory pipeline register or the memory/writeback pipeline register. The choice is made during decode and registered, so it is waiting at the execute muxes when the instruction arrives there.

When a load in execute produces a register that the decoding instruction needs as an ALU operand or as a store base address, the value cannot arrive in time. The block raises a stall that freezes the PC and the fetch/decode register, and a matching bubble request that loads a no-op into the decode/execute register. A load that feeds only the data operand of the very next store does not stall. The block instead carries a one-bit forward flag down two stages, so the memory-stage store-data mux takes the loaded value from the memory/writeback register. Producers three instructions ahead need no action, because the register file writes in the first half of the cycle and reads in the second.

Top module: `fwd_stall_ctrl`

## Requirements
- R1: While reset is applied and until the first vector after reset release is registered, `ex_sel_a` and `ex_sel_b` read 2'b00 and `mem_sd_fwd` reads 0.
- R2: If a used source matches the destination of a writing non-load in execute, that operand's select reads 2'b01 (execute/memory register) one cycle later, with no stall.
- R3: If a used source matches only the writing producer in the memory stage, that operand's select reads 2'b10 (memory/writeback register) one cycle later.
- R4: If a used source matches writing producers in both the execute and memory stages, the younger one wins and the select reads 2'b01.
- R5: If a writing load in execute matches `id_rs1` with `id_rs1_rd` set, or matches `id_rs2` with `id_rs2_rd` set and `id_store` clear, then `stall` and `bubble` are high in the same cycle. One cycle later both selects read 2'b00 and no store-data forward is issued.
- R6: If a writing load in execute matches `id_rs2` of a store (`id_rs2_rd` and `id_store` set) and no stall condition holds, there is no stall. `ex_sel_b` reads 2'b00 one cycle later, and `mem_sd_fwd` is 1 two cycles later.
- R7: A source index of 0 never matches. A producer whose valid or write-enable is low never matches. A source whose read flag is low gets select 2'b00 and causes no stall.
- R8: A source with no matching producer in execute or memory reads select 2'b00. A producer three ahead, which is not presented, is handled this way.
- R9: `mem_sd_fwd` is 1 exactly two cycles after a decode cycle that met the R6 condition, and 0 two cycles after any other decode cycle.
- R10: With `id_valid` low, `stall` and `bubble` stay low and both selects read 2'b00 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | REG_W | First source index |
| id_rs1_rd | input | 1 | First source is read (ALU operand or address base) |
| id_rs2 | input | REG_W | Second source index |
| id_rs2_rd | input | 1 | Second source is read |
| id_store | input | 1 | Instruction is a store; second source is its data |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_rd | input | REG_W | Execute-stage destination index |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | REG_W | Memory-stage destination index |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Load a no-op into decode/execute register |
| ex_sel_a | output | 2 | Registered select, first execute operand: 00 regfile, 01 EX/MEM, 10 MEM/WB |
| ex_sel_b | output | 2 | Registered select, second execute operand, same encoding |
| mem_sd_fwd | output | 1 | Memory-stage store data taken from MEM/WB register |

## Verification
The sweep covers every combination of indices and flags on a four-register configuration. It aims at a load in execute and an older ALU result in the memory stage that both match one source. A design that falls back to the older value there would show 2'b10 in place of a stall or a clean 2'b00. It also targets a store whose data comes from a load. Stalling there would show up as a needless `stall`, and dropping the flag or misplacing it by a cycle would show up on `mem_sd_fwd`. Register 0, disabled producers and unread sources are swept too, so a design that matches them would raise stalls or nonzero selects where none are expected.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } fwd_sel_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/hz_src_cmp.sv
module hz_src_cmp
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic             ex_ok,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_ok,
  input  logic [REG_W-1:0] mem_rd,
  output fwd_sel_e         sel,
  output logic             load_hit
);
  logic nz, ex_m, mem_m;

  always_comb begin
    nz       = (src != '0);
    ex_m     = nz && ex_ok  && (ex_rd  == src);
    mem_m    = nz && mem_ok && (mem_rd == src);
    load_hit = used && ex_m && ex_load;
    if (!used)        sel = SEL_RF;
    else if (ex_m)    sel = ex_load ? SEL_RF : SEL_EXMEM;
    else if (mem_m)   sel = SEL_MEMWB;
    else              sel = SEL_RF;
  end
endmodule

// File: rtl/hz_stage_regs.sv
module hz_stage_regs
  import hz_pkg::*;
(
  input  logic     clk,
  input  logic     rst_q_n,
  input  logic     adv_en,
  input  fwd_sel_e sel_a_d,
  input  fwd_sel_e sel_b_d,
  input  logic     sd_d,
  output fwd_sel_e sel_a_q,
  output fwd_sel_e sel_b_q,
  output logic     sd_mem_q
);
  logic sd_ex_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sel_a_q  <= SEL_RF;
      sel_b_q  <= SEL_RF;
      sd_ex_q  <= 1'b0;
      sd_mem_q <= 1'b0;
    end else if (adv_en) begin
      sel_a_q  <= sel_a_d;
      sel_b_q  <= sel_b_d;
      sd_ex_q  <= sd_d;
      sd_mem_q <= sd_ex_q;
    end
  end
endmodule

// File: rtl/fwd_stall_ctrl.sv
module fwd_stall_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs1,
  input  logic             id_rs1_rd,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_rs2_rd,
  input  logic             id_store,
  input  logic             ex_valid,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_valid,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_rd,
  output logic             stall,
  output logic             bubble,
  output logic [1:0]       ex_sel_a,
  output logic [1:0]       ex_sel_b,
  output logic             mem_sd_fwd
);
  logic             rst_q_n;
  logic             ex_ok, mem_ok;
  logic [REG_W-1:0] src_v  [NUM_SRC];
  logic             used_v [NUM_SRC];
  fwd_sel_e         sel_v  [NUM_SRC];
  logic             lh_v   [NUM_SRC];
  fwd_sel_e         sel_a_d, sel_b_d, sel_a_q, sel_b_q;
  logic             hold, sd_d, sd_q;

  hz_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign ex_ok     = ex_valid && ex_wen;
  assign mem_ok    = mem_valid && mem_wen;
  assign src_v[0]  = id_rs1;
  assign src_v[1]  = id_rs2;
  assign used_v[0] = id_rs1_rd;
  assign used_v[1] = id_rs2_rd;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hz_src_cmp #(.REG_W(REG_W)) u_cmp (
      .src      (src_v[s]),
      .used     (used_v[s]),
      .ex_ok    (ex_ok),
      .ex_load  (ex_load),
      .ex_rd    (ex_rd),
      .mem_ok   (mem_ok),
      .mem_rd   (mem_rd),
      .sel      (sel_v[s]),
      .load_hit (lh_v[s])
    );
  end

  // next-state: interlock and select decisions made in decode
  always_comb begin
    hold = id_valid && (lh_v[0] || (lh_v[1] && !id_store));
    sd_d = id_valid && !hold && id_store && lh_v[1];
    if (!id_valid || hold) begin
      sel_a_d = SEL_RF;
      sel_b_d = SEL_RF;
    end else begin
      sel_a_d = sel_v[0];
      sel_b_d = sel_v[1];
    end
  end

  hz_stage_regs u_regs (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .adv_en   (1'b1),
    .sel_a_d  (sel_a_d),
    .sel_b_d  (sel_b_d),
    .sd_d     (sd_d),
    .sel_a_q  (sel_a_q),
    .sel_b_q  (sel_b_q),
    .sd_mem_q (sd_q)
  );

  assign stall      = hold;
  assign bubble     = hold;
  assign ex_sel_a   = sel_a_q;
  assign ex_sel_b   = sel_b_q;
  assign mem_sd_fwd = sd_q;
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             id_valid,
  input logic [REG_W-1:0] id_rs1,
  input logic             id_rs1_rd,
  input logic [REG_W-1:0] id_rs2,
  input logic             id_rs2_rd,
  input logic             id_store,
  input logic             ex_valid,
  input logic             ex_wen,
  input logic             ex_load,
  input logic [REG_W-1:0] ex_rd,
  input logic             stall,
  input logic             bubble,
  input logic [1:0]       ex_sel_a,
  input logic [1:0]       ex_sel_b,
  input logic             mem_sd_fwd
);
  a_r5_bubble_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

  a_r5_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall |-> (ex_valid && ex_wen && ex_load && id_valid));

  a_r2_alu_bypass: assert property (@(posedge clk) disable iff (!rst_q_n)
    (id_valid && id_rs1_rd && id_rs1 != '0 && ex_valid && ex_wen && !ex_load
     && ex_rd == id_rs1) |=> (ex_sel_a == 2'b01));

  a_r6_store_data_no_stall: assert property (@(posedge clk) disable iff (!rst_q_n)
    (id_valid && id_store && id_rs2_rd && id_rs2 != '0 && ex_valid && ex_wen
     && ex_load && ex_rd == id_rs2 && !(id_rs1_rd && id_rs1 == id_rs2))
    |-> !stall ##1 1'b1 ##1 mem_sd_fwd);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    !id_valid |-> (!stall && !bubble) ##1 (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

  a_r8_legal_codes: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ex_sel_a != 2'b11 && ex_sel_b != 2'b11));
endmodule

bind fwd_stall_ctrl hz_checker #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .id_valid   (id_valid),
  .id_rs1     (id_rs1),
  .id_rs1_rd  (id_rs1_rd),
  .id_rs2     (id_rs2),
  .id_rs2_rd  (id_rs2_rd),
  .id_store   (id_store),
  .ex_valid   (ex_valid),
  .ex_wen     (ex_wen),
  .ex_load    (ex_load),
  .ex_rd      (ex_rd),
  .stall      (stall),
  .bubble     (bubble),
  .ex_sel_a   (ex_sel_a),
  .ex_sel_b   (ex_sel_b),
  .mem_sd_fwd (mem_sd_fwd)
);

// File: tb/test_fwd_stall_ctrl.sv
module test_fwd_stall_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 2;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_valid = 0, id_rs1_rd = 0, id_rs2_rd = 0, id_store = 0;
  logic [RW-1:0] id_rs1 = 0, id_rs2 = 0, ex_rd = 0, mem_rd = 0;
  logic ex_valid = 0, ex_wen = 0, ex_load = 0, mem_valid = 0, mem_wen = 0;
  logic stall, bubble, mem_sd_fwd;
  logic [1:0] ex_sel_a, ex_sel_b;

  int checks = 0, fails = 0;
  bit done = 0;

  int e_sel_a = 0, e_sel_b = 0, e_sd1 = 0, e_sd2 = 0;
  string t_sel_a = "R1", t_sel_b = "R1", t_sd1 = "R1", t_sd2 = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_stall_ctrl #(.REG_W(RW)) i_fwd_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1),
    .id_rs1_rd(id_rs1_rd), .id_rs2(id_rs2), .id_rs2_rd(id_rs2_rd),
    .id_store(id_store), .ex_valid(ex_valid), .ex_wen(ex_wen),
    .ex_load(ex_load), .ex_rd(ex_rd), .mem_valid(mem_valid),
    .mem_wen(mem_wen), .mem_rd(mem_rd), .stall(stall), .bubble(bubble),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .mem_sd_fwd(mem_sd_fwd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exm(input int r);
    return ex_valid && ex_wen && r != 0 && int'(ex_rd) == r;
  endfunction
  function automatic bit memm(input int r);
    return mem_valid && mem_wen && r != 0 && int'(mem_rd) == r;
  endfunction

  // operand source code from the requirements: 0 regfile, 1 EX/MEM, 2 MEM/WB
  function automatic int code(input int r, input bit used);
    if (!used) return 0;
    if (exm(r)) return ex_load ? 0 : 1;
    if (memm(r)) return 2;
    return 0;
  endfunction

  function automatic string tag_of(input int r, input bit used, input int c, input bit stl);
    if (!id_valid) return "R10";
    if (stl) return "R5";
    if (!used || r == 0) return "R7";
    if (c == 1) return memm(r) ? "R4" : "R2";
    if (c == 2) return "R3";
    return "R8";
  endfunction

  // check registered outputs, then present a new decode vector
  task automatic step();
    bit stl, sd;
    int ca, cb;
    @(negedge clk);
    chk(t_sel_a, ex_sel_a, e_sel_a);
    chk(t_sel_b, ex_sel_b, e_sel_b);
    chk(t_sd2, mem_sd_fwd, e_sd2);
    e_sd2 = e_sd1; t_sd2 = t_sd1;
  endtask

  task automatic expect_now();
    bit stl, sd;
    int ca, cb;
    #1;
    stl = id_valid && ex_load && ((id_rs1_rd && exm(int'(id_rs1))) ||
          (id_rs2_rd && !id_store && exm(int'(id_rs2))));
    sd = id_valid && !stl && id_rs2_rd && id_store && ex_load && exm(int'(id_rs2));
    ca = (id_valid && !stl) ? code(int'(id_rs1), id_rs1_rd) : 0;
    cb = (id_valid && !stl) ? code(int'(id_rs2), id_rs2_rd) : 0;
    chk(id_valid ? "R5" : "R10", stall, stl);
    chk(id_valid ? "R5" : "R10", bubble, stl);
    t_sel_a = tag_of(int'(id_rs1), id_rs1_rd, ca, stl);
    t_sel_b = tag_of(int'(id_rs2), id_rs2_rd, cb, stl);
    e_sel_a = ca; e_sel_b = cb;
    e_sd1 = sd; t_sd1 = sd ? "R6" : "R9";
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1", ex_sel_a, 0);
    chk("R1", ex_sel_b, 0);
    chk("R1", mem_sd_fwd, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", ex_sel_a, 0);
    chk("R1", mem_sd_fwd, 0);

    // exhaustive sweep of indices and flags on a four-register file
    for (int v = 0; v < (1 << 17); v++) begin
      step();
      id_rs1    = v[1:0];
      id_rs2    = v[3:2];
      id_rs1_rd = v[4];
      id_rs2_rd = v[5];
      id_store  = v[6];
      ex_rd     = v[8:7];
      ex_wen    = v[9];
      ex_load   = v[10];
      mem_rd    = v[12:11];
      mem_wen   = v[13];
      id_valid  = v[14];
      ex_valid  = v[15];
      mem_valid = v[16];
      expect_now();
    end

    // directed: load feeding only store data, then flush (R6, R9)
    step();
    id_valid = 1; id_store = 1; id_rs1_rd = 1; id_rs2_rd = 1;
    id_rs1 = 2'd1; id_rs2 = 2'd3;
    ex_valid = 1; ex_wen = 1; ex_load = 1; ex_rd = 2'd3;
    mem_valid = 1; mem_wen = 1; mem_rd = 2'd3;
    expect_now();
    // directed: disabled producers never match (R7)
    step();
    id_store = 0; id_rs1 = 2'd2; id_rs2 = 2'd2;
    ex_valid = 0; ex_rd = 2'd2; mem_valid = 1; mem_wen = 0; mem_rd = 2'd2;
    expect_now();
    for (int k = 0; k < 3; k++) begin
      step();
      id_valid = 0; ex_valid = 0; mem_valid = 0;
      expect_now();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule